// File: doc/BRIEF.md
# Critical-Word-First Refill Controller

This controller runs the refill of one cache line of eight words after a miss. It takes a miss request that carries the offset of the word the processor is waiting for. It then issues a single burst request to memory and gathers the returned beats, one word per beat, into a line buffer. It does not wait for the whole line before it restarts the processor. The needed word goes out on a forwarding port on the cycle after it arrives.

A mode input chooses how the burst is ordered. With wrap ordering, the burst starts at the missed word and wraps around the end of the line, so the needed word is always the first beat. With linear ordering, the burst starts at word 0 and runs upward, and the needed word is caught whenever it passes. Each beat is stored at its own word offset whatever the order. A line-complete pulse follows the final beat. While a refill is in progress, new miss requests are refused.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: While reset is active, and right after it is released, `miss_ready` is 1 and `mem_req_valid`, `crit_valid` and `line_done` are 0.
- R2: A miss is accepted on a clock edge where `miss_valid` and `miss_ready` are both 1. In the next cycle `mem_req_valid` is 1 for exactly one cycle and `miss_ready` is 0.
- R3: With `wrap_mode` = 1 at acceptance, `mem_req_start` equals `miss_word`. Beat k (counting from 0) is stored at word (`miss_word` + k) mod 8, so the missed word is the first beat.
- R4: With `wrap_mode` = 0 at acceptance, `mem_req_start` is 0 and beat k is stored at word k.
- R5: `crit_valid` pulses in the cycle after the beat that is stored at the missed word's offset, and `crit_data` then equals that beat's data.
- R6: Each refill produces exactly one `crit_valid` pulse.
- R7: `line_done` pulses for one cycle, in the cycle after the eighth accepted beat. From then on, `line_data` bits [32i+31:32i] hold the word stored at offset i, for i = 0..7.
- R8: While a refill is in progress, `miss_valid` is ignored. No new request is issued, and the refill continues with the word offset and mode latched at acceptance. A new miss can be accepted from the cycle in which `line_done` is high.
- R9: `mem_beat_valid` is ignored when no burst is in progress, which means while idle and during the cycle in which `mem_req_valid` is high. Such beats store nothing and do not advance the beat count.
- R10: An active-low reset in the middle of a refill abandons it. The controller returns to the idle state of R1, and the next refill behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Miss request present |
| miss_word | input | 3 | Offset of the needed word within the line |
| wrap_mode | input | 1 | 1: burst starts at the missed word and wraps; 0: burst starts at word 0 |
| miss_ready | output | 1 | Controller idle; a miss can be accepted |
| mem_req_valid | output | 1 | One-cycle burst request to memory |
| mem_req_start | output | 3 | Word offset of the first beat of the burst |
| mem_beat_valid | input | 1 | Memory returns one word this cycle |
| mem_beat_data | input | 32 | Returned word |
| crit_valid | output | 1 | One-cycle pulse: the needed word is on `crit_data` |
| crit_data | output | 32 | Forwarded needed word |
| line_done | output | 1 | One-cycle pulse after the last beat of the line |
| line_data | output | 256 | Line buffer; word i at bits [32i+31:32i] |

## Verification
The checker assumes that memory sends exactly eight beats per request. It also assumes that those beats arrive in the order implied by `mem_req_start` and the stated wrap rule, and that none arrive before the request cycle has passed. The bench models memory that way. It derives the start offset and beat order from the requirements, not from the request port. It sends stray beats only where R9 says they must be ignored, and then confirms that the following refill's ordering and completion timing are undisturbed. Gaps between beats are inserted only where the rules allow them: between beats of a burst in progress, and never inside the request cycle.

// File: rtl/cwf_refill_pkg.sv
package cwf_refill_pkg;
  localparam int unsigned LINE_WORDS = 8;
  localparam int unsigned WORD_BITS  = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2
  } refill_state_e;
endpackage

// File: rtl/cwf_beat_seq.sv
// Refill sequencer: accepts a miss, issues the burst request, counts beats
// and computes the line-buffer offset of each beat.
module cwf_beat_seq
  import cwf_refill_pkg::*;
#(
  parameter int unsigned WORDS = LINE_WORDS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         miss_valid,
  input  logic [$clog2(WORDS)-1:0]     miss_word,
  input  logic                         wrap_mode,
  input  logic                         beat_valid,
  output logic                         miss_ready,
  output logic                         req_valid,
  output logic [$clog2(WORDS)-1:0]     req_start,
  output logic                         beat_we,
  output logic [$clog2(WORDS)-1:0]     beat_idx,
  output logic                         beat_last,
  output logic [$clog2(WORDS)-1:0]     want_idx
);
  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(WORDS - 1);

  if ((1 << IDX_W) != WORDS) begin : g_bad_words
    $error("WORDS must be a power of two");
  end

  refill_state_e    state_q, state_d;
  logic [IDX_W-1:0] start_q, start_d;
  logic [IDX_W-1:0] want_q,  want_d;
  logic [IDX_W-1:0] cnt_q,   cnt_d;

  // Offset wraps naturally because WORDS is a power of two.
  assign beat_idx   = start_q + cnt_q;
  assign beat_we    = (state_q == ST_BURST) && beat_valid;
  assign beat_last  = beat_we && (cnt_q == LAST_CNT);
  assign miss_ready = (state_q == ST_IDLE);
  assign req_valid  = (state_q == ST_REQ);
  assign req_start  = start_q;
  assign want_idx   = want_q;

  always_comb begin
    state_d = state_q;
    start_d = start_q;
    want_d  = want_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (miss_valid) begin
          state_d = ST_REQ;
          want_d  = miss_word;
          start_d = wrap_mode ? miss_word : '0;
          cnt_d   = '0;
        end
      end
      ST_REQ: state_d = ST_BURST;
      ST_BURST: begin
        if (beat_we) begin
          cnt_d = cnt_q + 1'b1;
          if (beat_last) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= '0;
      want_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      want_q  <= want_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/cwf_line_buf.sv
// Line buffer: one enabled register per word, written at the beat offset.
module cwf_line_buf #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [WORDS*DATA_W-1:0]  line
);
  localparam int unsigned IDX_W = $clog2(WORDS);

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic          en;
    logic [DATA_W-1:0] word_q;

    assign en = we && (idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (en) word_q <= wdata;
    end

    assign line[i*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/cwf_crit_fwd.sv
// Forwards the needed word and flags completion, both registered.
module cwf_crit_fwd #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat_we,
  input  logic [$clog2(WORDS)-1:0] beat_idx,
  input  logic [$clog2(WORDS)-1:0] want_idx,
  input  logic                     beat_last,
  input  logic [DATA_W-1:0]        beat_data,
  output logic                     crit_valid,
  output logic [DATA_W-1:0]        crit_data,
  output logic                     line_done
);
  logic              hit;
  logic              crit_d, done_d;
  logic              crit_q, done_q;
  logic [DATA_W-1:0] data_q;

  assign hit    = beat_we && (beat_idx == want_idx);
  assign crit_d = hit;
  assign done_d = beat_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      crit_q <= crit_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hit) data_q <= beat_data;
  end

  assign crit_valid = crit_q;
  assign crit_data  = data_q;
  assign line_done  = done_q;
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl
  import cwf_refill_pkg::*;
#(
  parameter int unsigned WORDS  = LINE_WORDS,
  parameter int unsigned DATA_W = WORD_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_valid,
  input  logic [$clog2(WORDS)-1:0] miss_word,
  input  logic                     wrap_mode,
  output logic                     miss_ready,
  output logic                     mem_req_valid,
  output logic [$clog2(WORDS)-1:0] mem_req_start,
  input  logic                     mem_beat_valid,
  input  logic [DATA_W-1:0]        mem_beat_data,
  output logic                     crit_valid,
  output logic [DATA_W-1:0]        crit_data,
  output logic                     line_done,
  output logic [WORDS*DATA_W-1:0]  line_data
);
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic             beat_we, beat_last;
  logic [IDX_W-1:0] beat_idx, want_idx;

  cwf_beat_seq #(.WORDS(WORDS)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_word  (miss_word),
    .wrap_mode  (wrap_mode),
    .beat_valid (mem_beat_valid),
    .miss_ready (miss_ready),
    .req_valid  (mem_req_valid),
    .req_start  (mem_req_start),
    .beat_we    (beat_we),
    .beat_idx   (beat_idx),
    .beat_last  (beat_last),
    .want_idx   (want_idx)
  );

  cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) i_buf (
    .clk   (clk),
    .we    (beat_we),
    .idx   (beat_idx),
    .wdata (mem_beat_data),
    .line  (line_data)
  );

  cwf_crit_fwd #(.WORDS(WORDS), .DATA_W(DATA_W)) i_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_we    (beat_we),
    .beat_idx   (beat_idx),
    .want_idx   (want_idx),
    .beat_last  (beat_last),
    .beat_data  (mem_beat_data),
    .crit_valid (crit_valid),
    .crit_data  (crit_data),
    .line_done  (line_done)
  );
endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
  parameter int unsigned WORDS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     miss_valid,
  input logic [$clog2(WORDS)-1:0] miss_word,
  input logic                     wrap_mode,
  input logic                     miss_ready,
  input logic                     mem_req_valid,
  input logic [$clog2(WORDS)-1:0] mem_req_start,
  input logic                     mem_beat_valid,
  input logic                     crit_valid,
  input logic                     line_done
);
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic             acc_mode;
  logic [IDX_W-1:0] acc_word;
  logic [1:0]       crit_cnt;
  logic [IDX_W:0]   beat_cnt;
  logic             in_burst;

  assign in_burst = !miss_ready && !mem_req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_mode <= 1'b0;
      acc_word <= '0;
      crit_cnt <= '0;
      beat_cnt <= '0;
    end else begin
      if (miss_valid && miss_ready) begin
        acc_mode <= wrap_mode;
        acc_word <= miss_word;
      end
      if (mem_req_valid) begin
        crit_cnt <= '0;
        beat_cnt <= '0;
      end else begin
        if (crit_valid && crit_cnt != 2'd3) crit_cnt <= crit_cnt + 1'b1;
        if (in_burst && mem_beat_valid)     beat_cnt <= beat_cnt + 1'b1;
      end
    end
  end

  // R1: an idle controller never requests memory
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !mem_req_valid);

  // R2: acceptance leads to a request and a busy controller
  a_r2_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (mem_req_valid && !miss_ready));

  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R3: wrap ordering starts at the missed word
  a_r3_wrap_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && acc_mode) |-> (mem_req_start == acc_word));

  // R4: linear ordering starts at word 0
  a_r4_seq_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !acc_mode) |-> (mem_req_start == '0));

  // R5: in wrap ordering the forwarded word follows the first beat
  a_r5_wrap_crit_first: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_valid && acc_mode) |-> (beat_cnt == 1));

  // R6: exactly one forwarded word per refill
  a_r6_crit_once: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |-> (crit_cnt == 2'd0));

  a_r6_crit_by_done: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (crit_valid || crit_cnt != 2'd0));

  // R7: completion is a single pulse after the last beat
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  a_r7_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (beat_cnt == (IDX_W+1)'(WORDS)));

  // R8: a miss offered while busy raises no request
  a_r8_busy_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !miss_ready && !mem_req_valid) |=> !mem_req_valid);
endmodule

bind cwf_refill_ctrl cwf_refill_chk #(.WORDS(WORDS)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .miss_valid     (miss_valid),
  .miss_word      (miss_word),
  .wrap_mode      (wrap_mode),
  .miss_ready     (miss_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_start  (mem_req_start),
  .mem_beat_valid (mem_beat_valid),
  .crit_valid     (crit_valid),
  .line_done      (line_done)
);

// File: tb/test_cwf_refill_ctrl.sv
module test_cwf_refill_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 8;
  localparam int DATA_W     = 32;
  localparam int NVEC       = 8;

  // Vector layout: [20] wrap mode, [19:17] missed word, [16] gaps between beats,
  // [15:0] data seed.
  localparam logic [20:0] VECS [0:NVEC-1] = '{
    {1'b1, 3'd5, 1'b0, 16'hA5A5},
    {1'b0, 3'd5, 1'b0, 16'h1234},
    {1'b1, 3'd0, 1'b0, 16'h0F0F},
    {1'b0, 3'd7, 1'b1, 16'hBEEF},
    {1'b1, 3'd7, 1'b1, 16'hC0DE},
    {1'b0, 3'd0, 1'b0, 16'h7777},
    {1'b1, 3'd3, 1'b1, 16'h3C3C},
    {1'b0, 3'd2, 1'b0, 16'h9999}
  };

  logic                    clk;
  logic                    rst_n;
  logic                    miss_valid;
  logic [2:0]              miss_word;
  logic                    wrap_mode;
  logic                    miss_ready;
  logic                    mem_req_valid;
  logic [2:0]              mem_req_start;
  logic                    mem_beat_valid;
  logic [DATA_W-1:0]       mem_beat_data;
  logic                    crit_valid;
  logic [DATA_W-1:0]       crit_data;
  logic                    line_done;
  logic [WORDS*DATA_W-1:0] line_data;

  int n_checks = 0;
  int n_fail   = 0;

  cwf_refill_ctrl i_cwf_refill_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_word      (miss_word),
    .wrap_mode      (wrap_mode),
    .miss_ready     (miss_ready),
    .mem_req_valid  (mem_req_valid),
    .mem_req_start  (mem_req_start),
    .mem_beat_valid (mem_beat_valid),
    .mem_beat_data  (mem_beat_data),
    .crit_valid     (crit_valid),
    .crit_data      (crit_data),
    .line_done      (line_done),
    .line_data      (line_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] beat_word(input logic [15:0] seed, input int idx);
    return {seed, 13'd0, 3'(idx)};
  endfunction

  task automatic check_idle(input string req);
    check(miss_ready == 1'b1,    req, "miss_ready idle", miss_ready, 1);
    check(mem_req_valid == 1'b0, req, "mem_req_valid idle", mem_req_valid, 0);
    check(crit_valid == 1'b0,    req, "crit_valid idle", crit_valid, 0);
    check(line_done == 1'b0,     req, "line_done idle", line_done, 0);
  endtask

  // One complete refill. poke: offer a conflicting miss and flip inputs while busy.
  // junk_req: drive a stray beat during the request cycle.
  task automatic refill(input bit mode, input logic [2:0] w, input bit gap,
                        input logic [15:0] seed, input bit poke, input bit junk_req);
    logic [2:0]   exp_start;
    logic [255:0] exp_line;
    int           crits;
    exp_start = mode ? w : 3'd0;
    exp_line  = '0;
    crits     = 0;

    @(negedge clk);
    check(miss_ready == 1'b1, "R8", "ready before accept", miss_ready, 1);
    miss_valid = 1'b1; miss_word = w; wrap_mode = mode;
    @(negedge clk);
    if (poke) begin
      miss_word = w + 3'd3; wrap_mode = ~mode;
    end else begin
      miss_valid = 1'b0;
    end
    check(mem_req_valid == 1'b1, "R2", "request after accept", mem_req_valid, 1);
    check(miss_ready == 1'b0,    "R2", "busy after accept", miss_ready, 0);
    if (mode)
      check(mem_req_start == exp_start, "R3", "wrap start", mem_req_start, exp_start);
    else
      check(mem_req_start == exp_start, "R4", "linear start", mem_req_start, exp_start);
    if (junk_req) begin
      mem_beat_valid = 1'b1; mem_beat_data = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    mem_beat_valid = 1'b0;
    check(mem_req_valid == 1'b0, "R2", "request one cycle", mem_req_valid, 0);

    for (int k = 0; k < WORDS; k++) begin
      int idx;
      logic [31:0] d;
      idx = (exp_start + k) % WORDS;
      d = beat_word(seed, idx);
      exp_line[idx*32 +: 32] = d;
      mem_beat_valid = 1'b1; mem_beat_data = d;
      @(negedge clk);
      mem_beat_valid = 1'b0;
      if (k == WORDS-1) miss_valid = 1'b0;
      check(crit_valid == (idx == w), "R5", "crit_valid timing", crit_valid, (idx == w));
      if (crit_valid) begin
        crits++;
        check(crit_data == d, "R5", "crit_data value", crit_data, d);
      end
      if (mode && k == 0)
        check(crit_valid == 1'b1, "R3", "missed word first", crit_valid, 1);
      check(line_done == (k == WORDS-1), "R7", "line_done timing", line_done, (k == WORDS-1));
      if (poke && k < WORDS-1)
        check(mem_req_valid == 1'b0 && miss_ready == 1'b0, "R8", "busy miss ignored",
              {mem_req_valid, miss_ready}, 2'b00);
      if (gap && k < WORDS-1) begin
        @(negedge clk);
        check(crit_valid == 1'b0 && line_done == 1'b0, "R7", "no pulse in gap",
              {crit_valid, line_done}, 2'b00);
      end
    end
    check(crits == 1, "R6", "one forwarded word", crits, 1);
    check(line_data == exp_line, mode ? "R3" : "R4", "line buffer contents", line_data, exp_line);
    check(line_data == exp_line, "R7", "line complete", line_data, exp_line);
    check(miss_ready == 1'b1, "R8", "ready with line_done", miss_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_word = '0; wrap_mode = 1'b0;
    mem_beat_valid = 1'b0; mem_beat_data = '0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // Table-driven refills
    for (int v = 0; v < NVEC; v++) begin
      refill(VECS[v][20], VECS[v][19:17], VECS[v][16], VECS[v][15:0], 1'b0, 1'b0);
    end

    // R8: conflicting miss and flipped mode held during a refill
    refill(1'b1, 3'd6, 1'b0, 16'h5151, 1'b1, 1'b0);
    refill(1'b0, 3'd4, 1'b1, 16'h6262, 1'b1, 1'b0);

    // R9: stray beats while idle must not count
    @(negedge clk);
    mem_beat_valid = 1'b1; mem_beat_data = 32'hBAD0_0001;
    @(negedge clk);
    @(negedge clk);
    mem_beat_valid = 1'b0;
    check(crit_valid == 1'b0 && line_done == 1'b0, "R9", "idle beats ignored",
          {crit_valid, line_done}, 2'b00);
    refill(1'b1, 3'd2, 1'b0, 16'h7A7A, 1'b0, 1'b0);

    // R9: stray beat during the request cycle must not count
    refill(1'b1, 3'd1, 1'b0, 16'h8B8B, 1'b0, 1'b1);
    refill(1'b0, 3'd6, 1'b0, 16'h9C9C, 1'b0, 1'b1);

    // R10: reset in the middle of a refill
    @(negedge clk);
    miss_valid = 1'b1; miss_word = 3'd3; wrap_mode = 1'b0;
    @(negedge clk);
    miss_valid = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      mem_beat_valid = 1'b1; mem_beat_data = 32'h1111_0000 + k;
      @(negedge clk);
    end
    mem_beat_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check_idle("R10");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R10");
    refill(1'b1, 3'd4, 1'b0, 16'hD00D, 1'b0, 1'b0);
    refill(1'b0, 3'd1, 1'b0, 16'hE00E, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule